// File: doc/BRIEF.md
# Serial Flash Write-Protection Controller

This block holds the protection state of a 128K x 8 serial flash and rules on every command that would change the device. A command decoder ahead of it gives one-cycle strobes: latch set, latch clear, status write, page program, block erase and chip erase. With each strobe it also gives the target address, the proposed status byte and the level of the active-low write-protect pin. The block keeps a write enable latch, a two-bit protect-region code and a lock bit for the status register. It answers each modifying command with a registered accept or reject, one cycle after the strobe. It also shows its state as a status byte.

The lock bit and the pin together form a hardware-locked mode. In that mode the status register cannot be written, and the protected region cannot be changed. The mode is entered by whichever of the two comes last: setting the lock bit while the pin is low, or pulling the pin low while the bit is set. Raising the pin is the only way out. The protect-region code gives software protection against program and erase. That protection applies whether or not the hardware lock is in force.

Top module: `wp_guard`

## Requirements
- R1: After reset the status byte is 0x00 and resp_valid is 0.
- R2: A latch-set strobe makes status bit 1 (the write enable latch) read 1. A latch-clear strobe makes it read 0. Both take effect in the next cycle.
- R3: A status write, program or erase is rejected while the latch is 0. A rejection leaves status bits 7:2 unchanged. Every modifying command, accepted or rejected, leaves the latch at 0.
- R4: With the lock bit (status bit 7) at 0 and the latch set, a status write is accepted at either pin level. It copies bits 7 and 3:2 of the new byte into the status byte. All other bits of the new byte are ignored.
- R5: With the lock bit at 1 and the pin high, a status write is accepted if the latch is set.
- R6: With the lock bit at 1 and the pin low, every status write is rejected and status bits 7:2 stay unchanged. This holds whichever of the two conditions arose last.
- R7: Raising the pin ends the hardware lock. The next status write with the latch set is accepted again.
- R8: The protect-region code in status bits 3:2 maps as follows: 00 protects nothing, 01 protects addresses 0x18000 and above, 10 protects 0x10000 and above, and 11 protects the whole array. A page program or block erase to a protected address is rejected. One to an unprotected address is accepted with the latch set, including under the hardware lock.
- R9: Chip erase is rejected whenever the protect-region code is not 00. With code 00 and the latch set it is accepted.
- R10: resp_valid is 1 in the cycle after each modifying strobe and 0 otherwise. resp_accept is 1 only with resp_valid and an accepted command.
- R11: When several strobes arrive together, one command is served. The priority order is status write, page program, block erase, chip erase, latch set, latch clear. The strobes that lose are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wen | input | 1 | Latch-set strobe |
| cmd_wdis | input | 1 | Latch-clear strobe |
| cmd_wrsr | input | 1 | Status write strobe |
| cmd_prog | input | 1 | Page program strobe |
| cmd_berase | input | 1 | Block erase strobe |
| cmd_cerase | input | 1 | Chip erase strobe |
| addr | input | 17 | Target address for program or block erase |
| sr_new | input | 8 | Proposed status byte for a status write |
| wp_n | input | 1 | Write-protect pin, active low |
| resp_valid | output | 1 | A ruling is present this cycle |
| resp_accept | output | 1 | The ruling is accept |
| status | output | 8 | Status byte: bit 7 lock, bits 3:2 region code, bit 1 latch |

## Verification
A falling pin and a status write that meets a set lock bit can arrive in the same cycle. So can a latch-set strobe and a program strobe. The bench drives the pin low in the very cycle of a status write made while the lock bit is already set. The ruling must follow the pin level sampled in that cycle, so the write is rejected. The bench also raises a latch-set strobe and a program strobe together while the latch is clear. The program must be rejected and the latch must read 0 afterwards, which shows that the latch-set strobe was dropped. A bench model with the same priority order judges random mixed strobes as well.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  typedef enum logic [2:0] {
    OP_NONE, OP_WEN, OP_WDIS, OP_WRSR, OP_PROG, OP_BERASE, OP_CERASE
  } op_e;

  localparam int SR_W     = 8;
  localparam int WEL_POS  = 1;
  localparam int BP_LO    = 2;
  localparam int BP_W     = 2;
  localparam int LOCK_POS = 7;
endpackage

// File: rtl/wpg_arbiter.sv
module wpg_arbiter
  import wpg_pkg::*;
(
  input  logic cmd_wen,
  input  logic cmd_wdis,
  input  logic cmd_wrsr,
  input  logic cmd_prog,
  input  logic cmd_berase,
  input  logic cmd_cerase,
  output op_e  op
);
  always_comb begin
    if (cmd_wrsr)        op = OP_WRSR;
    else if (cmd_prog)   op = OP_PROG;
    else if (cmd_berase) op = OP_BERASE;
    else if (cmd_cerase) op = OP_CERASE;
    else if (cmd_wen)    op = OP_WEN;
    else if (cmd_wdis)   op = OP_WDIS;
    else                 op = OP_NONE;
  end
endmodule

// File: rtl/wpg_region.sv
module wpg_region #(
  parameter int ADDR_W = 17
) (
  input  logic [1:0]        bp,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  logic [1:0] top2;
  assign top2 = addr[ADDR_W-1 -: 2];

  always_comb begin
    case (bp)
      2'b01:   hit = (top2 == 2'b11);
      2'b10:   hit = top2[1];
      2'b11:   hit = 1'b1;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/wpg_policy.sv
module wpg_policy
  import wpg_pkg::*;
(
  input  op_e        op,
  input  logic       wel,
  input  logic       lock,
  input  logic [1:0] bp,
  input  logic       wp_n,
  input  logic       region_hit,
  output logic       is_mod,
  output logic       grant
);
  logic hw_locked;
  assign hw_locked = lock && !wp_n;

  always_comb begin
    is_mod = 1'b0;
    grant  = 1'b0;
    case (op)
      OP_WRSR: begin
        is_mod = 1'b1;
        grant  = wel && !hw_locked;
      end
      OP_PROG, OP_BERASE: begin
        is_mod = 1'b1;
        grant  = wel && !region_hit;
      end
      OP_CERASE: begin
        is_mod = 1'b1;
        grant  = wel && (bp == 2'b00);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/wp_guard.sv
module wp_guard
  import wpg_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wen,
  input  logic              cmd_wdis,
  input  logic              cmd_wrsr,
  input  logic              cmd_prog,
  input  logic              cmd_berase,
  input  logic              cmd_cerase,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SR_W-1:0]   sr_new,
  input  logic              wp_n,
  output logic              resp_valid,
  output logic              resp_accept,
  output logic [SR_W-1:0]   status
);
  op_e        op;
  logic       wel_q, lock_q;
  logic [1:0] bp_q;
  logic       hit, is_mod, grant;

  wpg_arbiter u_arb (
    .cmd_wen(cmd_wen), .cmd_wdis(cmd_wdis), .cmd_wrsr(cmd_wrsr),
    .cmd_prog(cmd_prog), .cmd_berase(cmd_berase), .cmd_cerase(cmd_cerase),
    .op(op)
  );

  wpg_region #(.ADDR_W(ADDR_W)) u_reg (
    .bp(bp_q), .addr(addr), .hit(hit)
  );

  wpg_policy u_pol (
    .op(op), .wel(wel_q), .lock(lock_q), .bp(bp_q), .wp_n(wp_n),
    .region_hit(hit), .is_mod(is_mod), .grant(grant)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wel_q       <= 1'b0;
      lock_q      <= 1'b0;
      bp_q        <= 2'b00;
      resp_valid  <= 1'b0;
      resp_accept <= 1'b0;
    end else begin
      resp_valid  <= is_mod;
      resp_accept <= is_mod && grant;
      if (is_mod) begin
        wel_q <= 1'b0;
        if (op == OP_WRSR && grant) begin
          lock_q <= sr_new[LOCK_POS];
          bp_q   <= sr_new[BP_LO +: BP_W];
        end
      end else if (op == OP_WEN) begin
        wel_q <= 1'b1;
      end else if (op == OP_WDIS) begin
        wel_q <= 1'b0;
      end
    end
  end

  always_comb begin
    status                 = '0;
    status[WEL_POS]        = wel_q;
    status[BP_LO +: BP_W]  = bp_q;
    status[LOCK_POS]       = lock_q;
  end
endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_wrsr,
  input logic       cmd_prog,
  input logic       cmd_berase,
  input logic       cmd_cerase,
  input logic       wp_n,
  input logic       resp_valid,
  input logic       resp_accept,
  input logic [7:0] status
);
  logic any_mod;
  assign any_mod = cmd_wrsr | cmd_prog | cmd_berase | cmd_cerase;

  // R3
  latch_clear_chk: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> !status[1]);

  // R3
  no_latch_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (any_mod && !status[1]) |=> (resp_valid && !resp_accept));

  // R6
  hw_lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (status[7] && !wp_n) |=> $stable(status[7:2]));

  // R9
  chip_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_cerase && !cmd_wrsr && !cmd_prog && !cmd_berase && status[3:2] != 2'b00)
      |=> (resp_valid && !resp_accept));

  // R10
  accept_valid_chk: assert property (@(posedge clk) disable iff (rst)
    resp_accept |-> resp_valid);
endmodule

bind wp_guard wp_guard_chk u_chk (
  .clk(clk), .rst(rst), .cmd_wrsr(cmd_wrsr), .cmd_prog(cmd_prog),
  .cmd_berase(cmd_berase), .cmd_cerase(cmd_cerase), .wp_n(wp_n),
  .resp_valid(resp_valid), .resp_accept(resp_accept), .status(status)
);

// File: tb/wp_guard_tb.sv
module wp_guard_tb;
  logic clk = 1'b0;
  logic rst;
  logic cmd_wen, cmd_wdis, cmd_wrsr, cmd_prog, cmd_berase, cmd_cerase;
  logic [16:0] addr;
  logic [7:0]  sr_new;
  logic        wp_n;
  logic        resp_valid, resp_accept;
  logic [7:0]  status;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic       m_wel, m_lock;
  logic [1:0] m_bp;

  always #4 clk = ~clk;

  wp_guard u_dut (
    .clk(clk), .rst(rst), .cmd_wen(cmd_wen), .cmd_wdis(cmd_wdis),
    .cmd_wrsr(cmd_wrsr), .cmd_prog(cmd_prog), .cmd_berase(cmd_berase),
    .cmd_cerase(cmd_cerase), .addr(addr), .sr_new(sr_new), .wp_n(wp_n),
    .resp_valid(resp_valid), .resp_accept(resp_accept), .status(status)
  );

  function automatic logic in_region(input logic [1:0] bp, input logic [16:0] a);
    case (bp)
      2'b01:   return a >= 17'h18000;
      2'b10:   return a >= 17'h10000;
      2'b11:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] m_status();
    return {m_lock, 3'b000, m_bp, m_wel, 1'b0};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Called at a negedge; applies one cycle of stimulus and checks the result at the next negedge.
  task automatic step(input logic wen, wdis, wrsr, prog, be, ce,
                      input logic [16:0] a, input logic [7:0] d, input logic wp, input string tag);
    logic ev, ea, mod;
    cmd_wen = wen; cmd_wdis = wdis; cmd_wrsr = wrsr; cmd_prog = prog;
    cmd_berase = be; cmd_cerase = ce; addr = a; sr_new = d; wp_n = wp;
    mod = wrsr | prog | be | ce;
    ev = mod; ea = 1'b0;
    if (wrsr)            ea = m_wel && !(m_lock && !wp);
    else if (prog || be) ea = m_wel && !in_region(m_bp, a);
    else if (ce)         ea = m_wel && (m_bp == 2'b00);
    if (mod) begin
      if (wrsr && ea) begin m_lock = d[7]; m_bp = d[3:2]; end
      m_wel = 1'b0;
    end else if (wen) m_wel = 1'b1;
    else if (wdis)    m_wel = 1'b0;
    @(posedge clk);
    #1;
    cmd_wen = 0; cmd_wdis = 0; cmd_wrsr = 0; cmd_prog = 0; cmd_berase = 0; cmd_cerase = 0;
    @(negedge clk);
    chk(resp_valid == ev && resp_accept == ea, {tag, " resp"}, {resp_valid, resp_accept}, {ev, ea});
    chk(status == m_status(), {tag, " status"}, status, m_status());
  endtask

  task automatic wen_step(input logic wp);
    step(1,0,0,0,0,0, 17'h0, 8'h0, wp, "R2");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1; cmd_wen = 0; cmd_wdis = 0; cmd_wrsr = 0; cmd_prog = 0;
    cmd_berase = 0; cmd_cerase = 0; addr = '0; sr_new = '0; wp_n = 1;
    m_wel = 0; m_lock = 0; m_bp = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(status == 8'h00 && !resp_valid, "R1 reset", {resp_valid, status}, 32'h0);

    // R2 latch set and clear
    wen_step(1);
    chk(status[1] == 1'b1, "R2 set", status, 8'h02);
    step(0,1,0,0,0,0, 17'h0, 8'h0, 1, "R2");
    chk(status[1] == 1'b0, "R2 clear", status, 8'h00);

    // R3 write with latch clear
    step(0,0,1,0,0,0, 17'h0, 8'h8C, 1, "R3");
    chk(!resp_accept && status == 8'h00, "R3 no latch", {resp_accept, status}, 32'h0);

    // R4 lock bit 0, pin low: accepted; extra bits ignored
    wen_step(0);
    step(0,0,1,0,0,0, 17'h0, 8'hF7, 0, "R4");
    chk(resp_accept && status == 8'h84, "R4 write pin low", {resp_accept, status}, {1'b1, 8'h84});

    // R6 now locked (bit set, pin low): write rejected
    wen_step(0);
    step(0,0,1,0,0,0, 17'h0, 8'h00, 0, "R6");
    chk(!resp_accept && status == 8'h84, "R6 locked", {resp_accept, status}, {1'b0, 8'h84});

    // R8 under lock, region 01
    wen_step(0);
    step(0,1'b0,0,1,0,0, 17'h17FFF, 8'h0, 0, "R8");
    chk(resp_accept, "R8 below region accepted", resp_accept, 1);
    wen_step(0);
    step(0,0,0,0,1,0, 17'h18000, 8'h0, 0, "R8");
    chk(!resp_accept, "R8 region edge rejected", resp_accept, 0);

    // R9 chip erase with region set
    wen_step(0);
    step(0,0,0,0,0,1, 17'h0, 8'h0, 0, "R9");
    chk(!resp_accept, "R9 chip erase guarded", resp_accept, 0);

    // R7 raise pin, write accepted
    wen_step(1);
    step(0,0,1,0,0,0, 17'h0, 8'h88, 1, "R7");
    chk(resp_accept && status == 8'h88, "R7 unlock", {resp_accept, status}, {1'b1, 8'h88});

    // R8 region 10
    wen_step(1);
    step(0,0,0,1,0,0, 17'h10000, 8'h0, 1, "R8");
    chk(!resp_accept, "R8 half region", resp_accept, 0);
    wen_step(1);
    step(0,0,0,1,0,0, 17'h0FFFF, 8'h0, 1, "R8");
    chk(resp_accept, "R8 below half", resp_accept, 1);

    // R5 lock set, pin high: accepted (sets region 11)
    wen_step(1);
    step(0,0,1,0,0,0, 17'h0, 8'h8C, 1, "R5");
    chk(resp_accept && status == 8'h8C, "R5 pin high", {resp_accept, status}, {1'b1, 8'h8C});
    wen_step(1);
    step(0,0,0,1,0,0, 17'h0, 8'h0, 1, "R8");
    chk(!resp_accept, "R8 whole array", resp_accept, 0);

    // R6 pin falls in the same cycle as the write
    wen_step(1);
    step(0,0,1,0,0,0, 17'h0, 8'h00, 0, "R6");
    chk(!resp_accept && status == 8'h8C, "R6 same-cycle pin drop", {resp_accept, status}, {1'b0, 8'h8C});

    // clear protection, then R9 accepted chip erase
    wen_step(1);
    step(0,0,1,0,0,0, 17'h0, 8'h00, 1, "R5");
    wen_step(1);
    step(0,0,0,0,0,1, 17'h0, 8'h0, 1, "R9");
    chk(resp_accept, "R9 chip erase open", resp_accept, 1);

    // R11 latch-set and program together, latch clear
    step(1,0,0,1,0,0, 17'h0, 8'h0, 1, "R11");
    chk(!resp_accept && status[1] == 1'b0, "R11 set strobe dropped", {resp_accept, status}, 32'h0);

    // R10 idle cycle
    step(0,0,0,0,0,0, 17'h0, 8'h0, 1, "R10");
    chk(!resp_valid, "R10 idle", resp_valid, 0);

    // random phase
    for (int i = 0; i < 600; i++) begin
      int r;
      logic [16:0] a;
      logic [7:0] d;
      logic wp;
      r = int'($urandom % 12);
      a = 17'($urandom);
      d = 8'($urandom);
      wp = ($urandom % 4) != 0;
      case (r)
        0, 1, 2, 3: step(1,0,0,0,0,0, a, d, wp, "R2");
        4:          step(0,1,0,0,0,0, a, d, wp, "R2");
        5, 6:       step(0,0,1,0,0,0, a, d, wp, "R4");
        7:          step(0,0,0,1,0,0, a, d, wp, "R8");
        8:          step(0,0,0,0,1,0, a, d, wp, "R8");
        9:          step(0,0,0,0,0,1, a, d, wp, "R9");
        10:         step(1,1,0,1,1,1, a, d, wp, "R11");
        default:    step(0,0,0,0,0,0, a, d, wp, "R10");
      endcase
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule